// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast clock by a programmable integer and produces one pulse per divide period. That pulse feeds a phase comparator. It is built as a dual-modulus prescaler that divides by P or P+1, a swallow count A and a main count B. The total ratio is N = B·P + A. The prescaler is modelled as synchronous logic in the same clock domain as the two counters.

Software writes the A value, the B value and a prescaler code, then strobes `load`. These values go into a holding stage first. They reach the counters only at the boundary between two divide periods, so a period that has already started always finishes with the settings it began with. The block checks each configuration as it is captured. A configuration it cannot divide by correctly is flagged and is never used.

Top module: `pdm_divider`

## Requirements
- R1: With A ≤ B and B ≥ 1, the spacing between consecutive `div_pulse` assertions is exactly B·P + A clock cycles. A is 6 bits and B is 13 bits. P is 8, 16, 32 or 64 for `psc_sel` = 0, 1, 2 or 3.
- R2: In each period the prescaler divides by P+1 for the first A prescaler cycles and by P for the rest. So A = 0 gives a period of B·P, and A = B gives a period of B·(P+1).
- R3: `div_pulse` is high for exactly one clock cycle per divide period.
- R4: A `load` sampled while the divider is running does not alter the period in progress. That period ends with the old spacing, and the new ratio applies from the next period.
- R5: After reset no pulse appears until a valid configuration is loaded. If `load` is sampled at edge k while the divider is idle, the first pulse goes high after edge k+1+N.
- R6: A `load` with A > B or B = 0 sets `cfg_err` from the following cycle. Such a configuration never reaches the counters, and the previous ratio continues. A later valid `load` clears `cfg_err`.
- R7: A synchronous active-high `rst` drives `div_pulse` and `cfg_err` low and clears both counters. It also discards any captured configuration, so the divider stays idle until the next `load`.
- R8: P = 32, A = 63, B = 891 gives a spacing of 28575 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture strobe for `a_in`, `b_in` and `psc_sel` |
| a_in | input | 6 | Swallow count A |
| b_in | input | 13 | Main count B |
| psc_sel | input | 2 | Prescaler code: 0→8, 1→16, 2→32, 3→64 |
| div_pulse | output | 1 | One-cycle pulse at the end of each divide period |
| cfg_err | output | 1 | Last captured configuration is invalid |

## Verification
The hardest situation to reach is a configuration change that lands partway through a running period. A single measurement of pulse spacing cannot separate the old ratio from the new one there. The stimulus therefore waits a fixed number of cycles after a pulse, strobes `load`, and adds those cycles to the count up to the next pulse. It expects the sum to equal the old ratio and the following spacing to equal the new one. Invalid configurations are loaded while a known ratio is running, and the spacing is measured to confirm that the ratio is unchanged.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  // Prescaler modulus code: P = 8 << code
  typedef enum logic [1:0] {
    PSC_8  = 2'd0,
    PSC_16 = 2'd1,
    PSC_32 = 2'd2,
    PSC_64 = 2'd3
  } psc_sel_e;

  localparam int PSC_BASE_LOG2 = 3;
  localparam int PSC_MAX_LOG2  = PSC_BASE_LOG2 + 3;
  // counter must reach P+1-1 = 64 for the largest modulus
  localparam int PC_W          = PSC_MAX_LOG2 + 1;

  // last count value of one prescaler cycle (modulus P or P+1)
  function automatic logic [PC_W-1:0] psc_last(input psc_sel_e sel, input logic swallow);
    int m;
    m = (1 << (PSC_BASE_LOG2 + int'(sel))) - 1 + (swallow ? 1 : 0);
    return PC_W'(m);
  endfunction

endpackage

// File: rtl/pdm_prescaler.sv
module pdm_prescaler
  import pdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     en,
  input  logic     restart,
  input  psc_sel_e sel,
  input  logic     swallow,
  output logic     wrap
);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] last;

  assign last = psc_last(sel, swallow);
  assign wrap = en && (pc == last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pc <= '0;
    end else if (en) begin
      pc <= wrap ? '0 : pc + 1'b1;
    end
  end

endmodule

// File: rtl/pdm_swallow_ctr.sv
module pdm_swallow_ctr #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           reload,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  input  logic           psc_wrap,
  output logic           swallow,
  output logic           terminal,
  output logic [A_W-1:0] a_cnt,
  output logic [B_W-1:0] b_cnt
);

  localparam logic [B_W-1:0] B_LAST = B_W'(1);

  assign swallow  = (a_cnt != '0);
  assign terminal = en && psc_wrap && (b_cnt == B_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_cnt <= '0;
      b_cnt <= '0;
    end else if (reload) begin
      a_cnt <= ld_a;
      b_cnt <= ld_b;
    end else if (en && psc_wrap) begin
      b_cnt <= b_cnt - 1'b1;
      if (swallow) a_cnt <= a_cnt - 1'b1;
    end
  end

endmodule

// File: rtl/pdm_cfg_hold.sv
module pdm_cfg_hold
  import pdm_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  psc_sel_e       sel_in,
  input  logic           xfer,
  output logic [A_W-1:0] hold_a,
  output logic [B_W-1:0] hold_b,
  output psc_sel_e       hold_sel,
  output logic           pend_ok,
  output logic           cfg_err
);

  logic pend;
  logic bad_in;

  assign bad_in  = (b_in == '0) || (B_W'(a_in) > b_in);
  assign pend_ok = pend && !cfg_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a   <= '0;
      hold_b   <= '0;
      hold_sel <= PSC_8;
      pend     <= 1'b0;
      cfg_err  <= 1'b0;
    end else if (load) begin
      hold_a   <= a_in;
      hold_b   <= b_in;
      hold_sel <= sel_in;
      pend     <= 1'b1;
      cfg_err  <= bad_in;
    end else if (xfer) begin
      pend     <= 1'b0;
    end
  end

endmodule

// File: rtl/pdm_divider.sv
module pdm_divider
  import pdm_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic [1:0]     psc_sel,
  output logic           div_pulse,
  output logic           cfg_err
);

  logic           armed;
  logic [A_W-1:0] act_a, hold_a, nxt_a, a_cnt;
  logic [B_W-1:0] act_b, hold_b, nxt_b, b_cnt;
  psc_sel_e       act_sel, hold_sel;
  logic           pend_ok, xfer, reload, terminal, swallow, psc_wrap;

  // new settings only cross at a period boundary, or at once when idle
  assign xfer   = pend_ok && (terminal || !armed);
  assign reload = terminal || xfer;
  assign nxt_a  = xfer ? hold_a : act_a;
  assign nxt_b  = xfer ? hold_b : act_b;

  pdm_cfg_hold #(.A_W(A_W), .B_W(B_W)) u_hold (
    .clk(clk), .rst(rst), .load(load), .a_in(a_in), .b_in(b_in),
    .sel_in(psc_sel_e'(psc_sel)), .xfer(xfer),
    .hold_a(hold_a), .hold_b(hold_b), .hold_sel(hold_sel),
    .pend_ok(pend_ok), .cfg_err(cfg_err)
  );

  pdm_prescaler u_psc (
    .clk(clk), .rst(rst), .en(armed), .restart(reload),
    .sel(act_sel), .swallow(swallow), .wrap(psc_wrap)
  );

  pdm_swallow_ctr #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk(clk), .rst(rst), .en(armed), .reload(reload),
    .ld_a(nxt_a), .ld_b(nxt_b), .psc_wrap(psc_wrap),
    .swallow(swallow), .terminal(terminal), .a_cnt(a_cnt), .b_cnt(b_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      act_a     <= '0;
      act_b     <= '0;
      act_sel   <= PSC_8;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= terminal;
      if (xfer) begin
        armed   <= 1'b1;
        act_a   <= hold_a;
        act_b   <= hold_b;
        act_sel <= hold_sel;
      end
    end
  end

endmodule

// File: rtl/pdm_divider_chk.sv
module pdm_divider_chk #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input logic           clk,
  input logic           rst,
  input logic           load,
  input logic [A_W-1:0] a_in,
  input logic [B_W-1:0] b_in,
  input logic           div_pulse,
  input logic           cfg_err,
  input logic           armed,
  input logic [A_W-1:0] a_cnt,
  input logic [B_W-1:0] b_cnt
);

  logic       seen_ok;
  logic       had_pulse;
  logic [3:0] gap;
  logic       in_bad;

  assign in_bad = (b_in == '0) || (B_W'(a_in) > b_in);

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_ok   <= 1'b0;
      had_pulse <= 1'b0;
      gap       <= '0;
    end else begin
      if (load && !in_bad) seen_ok <= 1'b1;
      had_pulse <= had_pulse | div_pulse;
      gap <= div_pulse ? 4'd0 : ((gap == 4'd15) ? gap : gap + 4'd1);
    end
  end

  // R1
  min_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (div_pulse && had_pulse) |-> (gap >= 4'd7));

  // R2
  swallow_bound_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (B_W'(a_cnt) <= b_cnt));

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_ok |-> !div_pulse);

  // R6
  cfg_flag_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (cfg_err == $past(in_bad)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!div_pulse && !cfg_err));

endmodule

bind pdm_divider pdm_divider_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk(clk), .rst(rst), .load(load), .a_in(a_in), .b_in(b_in),
  .div_pulse(div_pulse), .cfg_err(cfg_err), .armed(armed),
  .a_cnt(a_cnt), .b_cnt(b_cnt)
);

// File: tb/sim_pdm_divider.sv
module sim_pdm_divider;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load = 1'b0;
  logic [5:0]  a_in = '0;
  logic [12:0] b_in = '0;
  logic [1:0]  psc_sel = '0;
  logic        div_pulse;
  logic        cfg_err;

  int vectors = 0;
  int miscompares = 0;

  always #5 clk = ~clk;

  pdm_divider u0 (
    .clk(clk), .rst(rst), .load(load), .a_in(a_in), .b_in(b_in),
    .psc_sel(psc_sel), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  // stimulus table: A, B, prescaler code, periods measured
  localparam int NV = 8;
  localparam int VA [NV] = '{ 0,  1,  0,   5,  63, 63, 2, 40};
  localparam int VB [NV] = '{ 1,  1, 13, 100, 891, 63, 3, 70};
  localparam int VS [NV] = '{ 0,  0,  1,   2,   2,  3, 3,  0};
  localparam int VP [NV] = '{ 3,  3,  3,   3,   2,  3, 3,  3};

  function automatic string vtag(input int i);
    case (i)
      0, 1, 2, 5: return "R2";   // A=0 and A=B extremes
      4:          return "R8";   // 32/63/891 example
      default:    return "R1";
    endcase
  endfunction

  function automatic int ratio(input int a, input int b, input int s);
    return b * (8 << s) + a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int a, input int b, input int s);
    a_in = 6'(a); b_in = 13'(b); psc_sel = 2'(s); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  // counts negedges until div_pulse is seen high; -1 on timeout
  task automatic wait_pulse(input int limit, output int cyc);
    cyc = -1;
    for (int c = 1; c <= limit; c++) begin
      @(negedge clk);
      if (div_pulse) begin cyc = c; return; end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    miscompares++; vectors++;
    $display("FAIL R1: watchdog got %0d cycles expected completion", 190000);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int w, cur_n, c;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(div_pulse == 1'b0, "R7 pulse in reset", int'(div_pulse), 0);
    chk(cfg_err == 1'b0, "R7 err in reset", int'(cfg_err), 0);
    rst = 1'b0;
    // R5 idle without a load
    wait_pulse(200, w);
    chk(w == -1, "R5 idle", w, -1);

    // R5 first-period latency, N = 8
    @(negedge clk);
    do_load(0, 1, 0);
    wait_pulse(100, w);
    chk(w == 9, "R5 first pulse", w, 9);
    wait_pulse(100, w);
    chk(w == 8, "R1 spacing", w, 8);
    cur_n = 8;

    // table walk
    for (int i = 0; i < NV; i++) begin
      do_load(VA[i], VB[i], VS[i]);
      wait_pulse(cur_n + 4, w);
      cur_n = ratio(VA[i], VB[i], VS[i]);
      for (int p = 0; p < VP[i]; p++) begin
        wait_pulse(cur_n + 4, w);
        chk(w == cur_n, vtag(i), w, cur_n);
      end
    end

    // R1 pseudo-random legal settings
    for (int k = 0; k < 3; k++) begin
      int ra, rb, rs;
      rb = int'($urandom_range(60, 1));
      ra = int'($urandom_range(rb, 0));
      rs = int'($urandom_range(3, 0));
      do_load(ra, rb, rs);
      wait_pulse(cur_n + 4, w);
      cur_n = ratio(ra, rb, rs);
      for (int p = 0; p < 3; p++) begin
        wait_pulse(cur_n + 4, w);
        chk(w == cur_n, "R1 random", w, cur_n);
      end
    end

    // R6 invalid A > B while running
    do_load(10, 5, 0);
    chk(cfg_err == 1'b1, "R6 A>B flag", int'(cfg_err), 1);
    wait_pulse(cur_n + 4, w);
    wait_pulse(cur_n + 4, w);
    chk(w == cur_n, "R6 ratio kept", w, cur_n);
    do_load(0, 0, 2);
    chk(cfg_err == 1'b1, "R6 B=0 flag", int'(cfg_err), 1);
    do_load(3, 4, 1);
    chk(cfg_err == 1'b0, "R6 cleared", int'(cfg_err), 0);
    wait_pulse(cur_n + 4, w);
    cur_n = 67;
    wait_pulse(cur_n + 4, w);
    chk(w == cur_n, "R6 valid after error", w, cur_n);

    // R4 load in mid-period: old spacing finishes, then new one
    c = 0;
    repeat (3) @(negedge clk);
    c = 3;
    do_load(1, 2, 0);
    c = c + 1;
    wait_pulse(cur_n + 4, w);
    chk(c + w == 67, "R4 old period kept", c + w, 67);
    wait_pulse(40, w);
    chk(w == 17, "R4 new period", w, 17);

    // R7 reset while running, with an error flag and pending config
    do_load(9, 3, 0);
    chk(cfg_err == 1'b1, "R6 flag before reset", int'(cfg_err), 1);
    do_load(2, 2, 0);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(div_pulse == 1'b0, "R7 pulse cleared", int'(div_pulse), 0);
    chk(cfg_err == 1'b0, "R7 err cleared", int'(cfg_err), 0);
    rst = 1'b0;
    wait_pulse(300, w);
    chk(w == -1, "R7 pending discarded", w, -1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule